// File: doc/BRIEF.md
# Ramped Digital Volume Control

This block scales a stream of signed 24-bit PCM samples by a linear gain word that software programs. It does not jump straight to a new setting. Each time a sample is accepted, the applied gain moves a programmable fraction of the remaining distance toward the target. The result is a first-order exponential glide that avoids audible clicks. Software converts decibels to linear words and computes the ramp coefficient. The block only does the arithmetic.

Two 32-bit registers are written through a simple write strobe. The target gain is unsigned with 30 fractional bits, so `0x4000_0000` is unity and 0 dB. The ramp coefficient is unsigned with 31 fractional bits. Each gain update adds `floor((target - applied) * coefficient / 2^31)` to the applied gain. A coefficient of zero, or any coefficient at or above `0x8000_0000`, makes a new target take effect on the next sample. When the fractional step rounds to nothing while a gap remains, the gain lands on the target exactly.

The gain sequencer has two named states:
- HOLD: the applied gain equals the target.
- GLIDE: a gap remains between the applied gain and the target.

The transitions are:
- HOLD to GLIDE: software writes a target that differs from the applied gain.
- GLIDE to HOLD: an accepted sample's update lands on the target.
- Any target write that equals the applied gain (after that cycle's update) leads to HOLD.

Samples pass through a two-register pipeline with valid/ready on both sides.

Top module: `gain_glide`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high, and the applied gain and the target are both unity, so samples pass unchanged.
- R2: With the coefficient register at zero, the first sample accepted after a target write is scaled by the new target exactly.
- R3: With a coefficient c between 1 and `0x7FFF_FFFF`, each accepted sample first sets gain := gain + floor((target - gain) * c / 2^31). Here target - gain is a signed 33-bit difference. The sample is then scaled by the updated gain, and the gain never passes the target.
- R4: The applied gain changes only on a cycle where `in_valid` and `in_ready` are both high. Idle cycles and stalled cycles leave it untouched.
- R5: When the R3 step is zero but the gain differs from the target, the gain is set equal to the target. A downward step is never smaller than one LSB.
- R6: A coefficient at or above `0x8000_0000` acts as unity, so the gain reaches the target in one update.
- R7: `out_data` = floor(sample * gain / 2^30), with the sample taken as signed two's complement.
- R8: Results above `0x7F_FFFF` give `0x7F_FFFF`, and results below `-0x80_0000` give `0x80_0000`.
- R9: A target write during a ramp continues the glide from the present applied gain toward the new target.
- R10: A sample accepted at rising edge n appears on `out_data` with `out_valid` high right after edge n+1 when the output is not stalled. `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A held output keeps its data.
- R11: `cfg_addr` 0 selects the target gain and 1 selects the coefficient. A sample accepted in the same cycle as a write is processed with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = target gain, 1 = ramp coefficient |
| cfg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Sink takes the output sample |
| out_data | output | 24 | Signed scaled sample |

## Verification
The bench targets the following corner cases:

- **Rounding toward minus infinity on negative samples.** A design that truncates toward zero gives -1 instead of -2 for -3 at half gain.
- **Saturation at both rails.** A missing clamp wraps a doubled full-scale sample into the opposite sign.
- **The snap rule in both directions.** Without it, a one-LSB coefficient leaves the gain stuck forever below a larger target.
- **Out-of-range coefficients.** An unclamped coefficient overshoots the target or wraps the gain word.
- **Idle and stalled cycles inside a ramp, and target writes mid-ramp or in the same cycle as a sample.** A design that advances the gain per clock, or that restarts the ramp, produces a different output sequence from the bench's sample-by-sample model.

// File: rtl/gg_pkg.sv
`timescale 1ns/1ps
package gg_pkg;

    // gain sequencer states
    typedef enum logic [0:0] {
        ST_HOLD  = 1'b0,
        ST_GLIDE = 1'b1
    } glide_st_e;

    // register selector values
    localparam logic ADDR_TARGET = 1'b0;
    localparam logic ADDR_COEF   = 1'b1;

endpackage

// File: rtl/gg_step.sv
`timescale 1ns/1ps
// One exponential smoothing update of the applied gain.
module gg_step #(
    parameter int GAIN_W    = 32,
    parameter int COEF_W    = 32,
    parameter int COEF_FRAC = 31
) (
    input  logic [GAIN_W-1:0] cur_i,
    input  logic [GAIN_W-1:0] tgt_i,
    input  logic [COEF_W-1:0] coef_i,
    output logic [GAIN_W-1:0] nxt_o
);
    localparam int DIFF_W = GAIN_W + 1;
    localparam int CEFF_W = COEF_FRAC + 1;
    localparam int PROD_W = DIFF_W + CEFF_W + 1;
    localparam int SUM_W  = DIFF_W + 1;
    localparam logic [CEFF_W-1:0] UNITY_C = {1'b1, {COEF_FRAC{1'b0}}};
    localparam logic [COEF_W-1:0] UNITY_W = COEF_W'(UNITY_C);

    logic signed [DIFF_W-1:0] diff;
    logic        [CEFF_W-1:0] ceff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] step;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        diff = $signed({1'b0, tgt_i}) - $signed({1'b0, cur_i});
        // coefficient clamped to unity so the update never overshoots
        ceff = (coef_i >= UNITY_W) ? UNITY_C : coef_i[CEFF_W-1:0];
        prod = PROD_W'(diff) * PROD_W'($signed({1'b0, ceff}));
        step = prod >>> COEF_FRAC;
        sum  = $signed({2'b00, cur_i}) + SUM_W'(step);
        if (coef_i == '0) begin
            nxt_o = tgt_i;
        end else if ((step == '0) && (diff != '0)) begin
            nxt_o = tgt_i;
        end else begin
            nxt_o = GAIN_W'(sum);
        end
    end
endmodule

// File: rtl/gg_ramp_ctrl.sv
`timescale 1ns/1ps
// Holds the target, coefficient and applied gain; sequences the glide.
module gg_ramp_ctrl
    import gg_pkg::*;
#(
    parameter int GAIN_W    = 32,
    parameter int COEF_W    = 32,
    parameter int GAIN_FRAC = 30,
    parameter int COEF_FRAC = 31,
    parameter int CFG_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              adv_i,
    output logic [GAIN_W-1:0] gain_o,
    output logic [GAIN_W-1:0] tgt_o,
    output logic [COEF_W-1:0] coef_o,
    output logic              gliding_o
);
    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'({1'b1, {GAIN_FRAC{1'b0}}});

    glide_st_e         st_q, st_d;
    logic [GAIN_W-1:0] tgt_q, cur_q, cur_d, step_nxt;
    logic [COEF_W-1:0] coef_q;
    logic              wr_tgt, wr_coef;
    logic [GAIN_W-1:0] wr_gain;
    logic [COEF_W-1:0] wr_cval;

    assign wr_tgt  = cfg_we && (cfg_addr == ADDR_TARGET);
    assign wr_coef = cfg_we && (cfg_addr == ADDR_COEF);
    assign wr_gain = GAIN_W'(cfg_wdata);
    assign wr_cval = COEF_W'(cfg_wdata);

    gg_step #(
        .GAIN_W   (GAIN_W),
        .COEF_W   (COEF_W),
        .COEF_FRAC(COEF_FRAC)
    ) u_step (
        .cur_i (cur_q),
        .tgt_i (tgt_q),
        .coef_i(coef_q),
        .nxt_o (step_nxt)
    );

    // next-state and next-gain decision
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        unique case (st_q)
            ST_HOLD: begin
                cur_d = cur_q;
            end
            ST_GLIDE: begin
                if (adv_i) begin
                    cur_d = step_nxt;
                    if (step_nxt == tgt_q) begin
                        st_d = ST_HOLD;
                    end
                end
            end
        endcase
        if (wr_tgt) begin
            st_d = (wr_gain == cur_d) ? ST_HOLD : ST_GLIDE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= GAIN_UNITY;
            cur_q  <= GAIN_UNITY;
            coef_q <= '0;
        end else begin
            cur_q <= cur_d;
            if (wr_tgt) begin
                tgt_q <= wr_gain;
            end
            if (wr_coef) begin
                coef_q <= wr_cval;
            end
        end
    end

    // outputs
    always_comb begin
        gain_o    = cur_q;
        tgt_o     = tgt_q;
        coef_o    = coef_q;
        gliding_o = (st_q == ST_GLIDE);
    end
endmodule

// File: rtl/gg_scale.sv
`timescale 1ns/1ps
// Sample times gain, floor shift, saturate to sample width.
module gg_scale #(
    parameter int SAMPLE_W  = 24,
    parameter int GAIN_W    = 32,
    parameter int GAIN_FRAC = 30
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [GAIN_W-1:0]   gain_i,
    output logic signed [SAMPLE_W-1:0] scaled_o
);
    localparam int P_W = SAMPLE_W + GAIN_W + 1;
    localparam logic signed [P_W-1:0] MAXV = {{(P_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [P_W-1:0] MINV = {{(P_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] shifted;

    always_comb begin
        prod    = P_W'(sample_i) * P_W'($signed({1'b0, gain_i}));
        shifted = prod >>> GAIN_FRAC;
        if (shifted > MAXV) begin
            scaled_o = MAXV[SAMPLE_W-1:0];
        end else if (shifted < MINV) begin
            scaled_o = MINV[SAMPLE_W-1:0];
        end else begin
            scaled_o = shifted[SAMPLE_W-1:0];
        end
    end
endmodule

// File: rtl/gg_pipe.sv
`timescale 1ns/1ps
// Two-register sample pipeline with a shared advance enable.
module gg_pipe #(
    parameter int SAMPLE_W  = 24,
    parameter int GAIN_W    = 32,
    parameter int GAIN_FRAC = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic [GAIN_W-1:0]   gain_i,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                accept_o
);
    logic                       adv;
    logic                       s1_v;
    logic signed [SAMPLE_W-1:0] s1_d;
    logic signed [SAMPLE_W-1:0] scaled;

    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;
    assign accept_o = adv && in_valid;

    gg_scale #(
        .SAMPLE_W (SAMPLE_W),
        .GAIN_W   (GAIN_W),
        .GAIN_FRAC(GAIN_FRAC)
    ) u_scale (
        .sample_i(s1_d),
        .gain_i  (gain_i),
        .scaled_o(scaled)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v      <= 1'b0;
            s1_d      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (adv) begin
            s1_v      <= in_valid;
            s1_d      <= $signed(in_data);
            out_valid <= s1_v;
            out_data  <= scaled;
        end
    end
endmodule

// File: rtl/gain_glide.sv
`timescale 1ns/1ps
// Top: ramped linear volume scaler.
module gain_glide #(
    parameter int SAMPLE_W  = 24,
    parameter int GAIN_W    = 32,
    parameter int COEF_W    = 32,
    parameter int GAIN_FRAC = 30,
    parameter int COEF_FRAC = 31,
    parameter int CFG_W     = (GAIN_W > COEF_W) ? GAIN_W : COEF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data
);
    logic              accept;
    logic [GAIN_W-1:0] cur_gain;
    logic [GAIN_W-1:0] tgt_gain;
    logic [COEF_W-1:0] ramp_coef;
    logic              gliding;

    gg_ramp_ctrl #(
        .GAIN_W   (GAIN_W),
        .COEF_W   (COEF_W),
        .GAIN_FRAC(GAIN_FRAC),
        .COEF_FRAC(COEF_FRAC),
        .CFG_W    (CFG_W)
    ) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .adv_i    (accept),
        .gain_o   (cur_gain),
        .tgt_o    (tgt_gain),
        .coef_o   (ramp_coef),
        .gliding_o(gliding)
    );

    gg_pipe #(
        .SAMPLE_W (SAMPLE_W),
        .GAIN_W   (GAIN_W),
        .GAIN_FRAC(GAIN_FRAC)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .gain_i   (cur_gain),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data),
        .accept_o (accept)
    );
endmodule

// File: rtl/gain_glide_chk.sv
`timescale 1ns/1ps
module gain_glide_chk #(
    parameter int SAMPLE_W  = 24,
    parameter int GAIN_W    = 32,
    parameter int COEF_W    = 32,
    parameter int COEF_FRAC = 31
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                out_valid,
    input logic                out_ready,
    input logic [SAMPLE_W-1:0] out_data,
    input logic [GAIN_W-1:0]   cur_gain,
    input logic [GAIN_W-1:0]   tgt_gain,
    input logic [COEF_W-1:0]   ramp_coef,
    input logic                gliding
);
    localparam logic [COEF_W-1:0] C_UNITY = COEF_W'({1'b1, {COEF_FRAC{1'b0}}});

    // R2
    zero_coef_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ramp_coef == '0) |=> (cur_gain == $past(tgt_gain)));

    // R4
    gain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(cur_gain));

    // R3
    no_overshoot_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && tgt_gain >= cur_gain)
        |=> (cur_gain >= $past(cur_gain) && cur_gain <= $past(tgt_gain)));

    // R3
    no_overshoot_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && tgt_gain < cur_gain)
        |=> (cur_gain < $past(cur_gain) && cur_gain >= $past(tgt_gain)));

    // R6
    big_coef_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && ramp_coef >= C_UNITY) |=> (cur_gain == $past(tgt_gain)));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R5
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gliding && !(in_valid && in_ready)) |=> $stable(cur_gain));
endmodule

bind gain_glide gain_glide_chk #(
    .SAMPLE_W (SAMPLE_W),
    .GAIN_W   (GAIN_W),
    .COEF_W   (COEF_W),
    .COEF_FRAC(COEF_FRAC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .cur_gain (cur_gain),
    .tgt_gain (tgt_gain),
    .ramp_coef(ramp_coef),
    .gliding  (gliding)
);

// File: tb/tb_gain_glide.sv
`timescale 1ns/1ps
module tb_gain_glide;
    localparam int SW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_addr = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [SW-1:0] out_data;

    always #2.5 clk = ~clk;

    gain_glide dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    int            n_tests = 0;
    int            n_fail = 0;
    int            cyc = 0;
    int            last_stall = -1;
    bit            done = 0;
    string         req = "R1";
    longint        m_tgt = 64'sd1073741824;
    longint        m_coef = 0;
    longint        m_cur = 64'sd1073741824;
    logic [SW-1:0] exp_q[$];
    int            due_q[$];
    bit            hold_pend = 0;
    logic [SW-1:0] hold_val = '0;

    task automatic fail(input string r, input longint act, input longint exp);
        n_fail++;
        $display("FAIL %s: actual %0d expected %0d (cycle %0d)", r, act, exp, cyc);
    endtask

    // behavioural gain update for one accepted sample (R3, R5, R6, R2)
    task automatic model_gain();
        longint d, c, s;
        if (m_coef == 0) begin
            m_cur = m_tgt;
        end else begin
            c = (m_coef >= 64'sd2147483648) ? 64'sd2147483648 : m_coef;
            d = m_tgt - m_cur;
            s = (d * c) >>> 31;
            if (s == 0 && d != 0) m_cur = m_tgt;
            else m_cur = m_cur + s;
        end
    endtask

    // R7 and R8 expected result
    function automatic logic [SW-1:0] model_out(input logic signed [SW-1:0] x);
        longint p;
        p = (longint'(x) * m_cur) >>> 30;
        if (p > 64'sd8388607) p = 64'sd8388607;
        if (p < -64'sd8388608) p = -64'sd8388608;
        return SW'(p);
    endfunction

    task automatic tick(input logic iv, input logic [SW-1:0] id, input logic ordy,
                        input logic we, input logic ad, input logic [31:0] wd);
        logic [SW-1:0] e;
        int            d;
        in_valid = iv; in_data = id; out_ready = ordy;
        cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
        #1;
        if (hold_pend) begin   // R10 held output
            n_tests++;
            if (!out_valid || out_data !== hold_val) fail("R10 hold", longint'(out_data), longint'(hold_val));
        end
        if (out_valid && out_ready) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                fail({req, " unexpected output"}, longint'(out_data), 0);
            end else begin
                e = exp_q.pop_front();
                d = due_q.pop_front();
                if (out_data !== e) fail(req, longint'($signed(out_data)), longint'($signed(e)));
                if (last_stall < d) begin
                    n_tests++;
                    if (cyc - d != 2) fail("R10 latency", cyc - d, 2);
                end
            end
        end
        hold_pend = out_valid && !out_ready;
        hold_val  = out_data;
        if (hold_pend) last_stall = cyc;
        n_tests++;   // R10 ready rule
        if (in_ready !== (!out_valid || out_ready)) fail("R10 ready", in_ready, !out_valid || out_ready);
        if (iv && in_ready) begin
            model_gain();
            exp_q.push_back(model_out($signed(id)));
            due_q.push_back(cyc);
        end
        if (we) begin   // R11 selector: 0 target, 1 coefficient
            if (ad) m_coef = longint'(wd);
            else m_tgt = longint'(wd);
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic wr(input logic ad, input logic [31:0] wd);
        tick(1'b0, '0, 1'b1, 1'b1, ad, wd);
    endtask

    task automatic put(input logic [SW-1:0] x);
        tick(1'b1, x, 1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, '0, 1'b1, 1'b0, 1'b0, '0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fail("watchdog", cyc, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        n_tests++; if (out_valid !== 1'b0) fail("R1 out_valid", out_valid, 0);
        n_tests++; if (in_ready !== 1'b1) fail("R1 in_ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 unity passthrough, R7 values
        req = "R1";
        put(24'h000000); put(24'h000001); put(24'hFFFFFF);
        put(24'h7FFFFF); put(24'h800000); put(24'd12345);
        idle(3);

        // R11 select, R2 immediate gain, R7 floor rounding at half gain
        req = "R2";
        wr(1'b1, 32'h0); wr(1'b0, 32'h2000_0000);
        put(24'hFFFFFD); put(24'hFFFFFF); put(24'd1); put(24'd3); put(24'h7FFFFF);
        req = "R7";
        put(24'hFFFFFB); put(24'd5);
        idle(3);

        // R8 saturation at double gain
        req = "R8";
        wr(1'b0, 32'h8000_0000);
        put(24'h7FFFFF); put(24'h800000); put(24'h300000); put(24'h500000); put(24'hD00000);
        idle(3);

        // R3 exponential glide down
        req = "R3";
        wr(1'b1, 32'h1000_0000); wr(1'b0, 32'h4000_0000);
        for (int i = 0; i < 30; i++) put(24'h200000);
        idle(3);

        // R4 idle and stalled cycles inside a ramp
        req = "R4";
        wr(1'b0, 32'h0100_0000);
        put(24'h300000); put(24'h300000); put(24'h300000);
        idle(5);
        put(24'h300000); put(24'h300000);
        for (int i = 0; i < 5; i++) tick(1'b1, 24'h300000, 1'b0, 1'b0, 1'b0, '0);
        put(24'h300000); put(24'h300000);
        idle(3);

        // R9 retarget mid-ramp
        req = "R9";
        wr(1'b1, 32'h0800_0000); wr(1'b0, 32'h8000_0000);
        for (int i = 0; i < 5; i++) put(24'h200000);
        wr(1'b0, 32'h1000_0000);
        for (int i = 0; i < 20; i++) put(24'h200000);
        idle(3);

        // R11 write in the same cycle as an accepted sample
        req = "R11";
        tick(1'b1, 24'h200000, 1'b1, 1'b1, 1'b0, 32'h6000_0000);
        put(24'h200000);
        tick(1'b1, 24'h200000, 1'b1, 1'b1, 1'b1, 32'h0);
        put(24'h200000); put(24'h200000);
        idle(3);

        // R5 snap upward and minimal downward step with a one-LSB coefficient
        req = "R5";
        wr(1'b1, 32'h0); wr(1'b0, 32'h4000_0000); put(24'h100000);
        wr(1'b1, 32'h1); wr(1'b0, 32'h8000_0000);
        put(24'h100000); put(24'h100000);
        wr(1'b0, 32'h4000_0000);
        put(24'h100000); put(24'h100000); put(24'h100000);
        idle(3);

        // R6 coefficient above unity
        req = "R6";
        wr(1'b1, 32'hFFFF_FFFF); wr(1'b0, 32'h1000_0000);
        put(24'h400000); put(24'h400000);
        wr(1'b1, 32'h8000_0000); wr(1'b0, 32'h4000_0000);
        put(24'h400000); put(24'h400000);
        idle(4);

        n_tests++;
        if (exp_q.size() != 0) fail("R10 outputs missing", exp_q.size(), 0);
        summary();
    end
endmodule